// File: doc/BRIEF.md
# Linked-List DMA Descriptor Engine

A single-channel DMA engine that walks a chain of four-word descriptors in memory. Software loads the pointer to the first descriptor, clears stale status flags and sets the channel enable bit. From then on the engine reloads its own live source, destination, next-pointer and control registers from each descriptor. It copies one block of 32-bit words, marks the descriptor done, and follows the next pointer. It does not stop to let software acknowledge block completion.

All memory traffic uses one word-wide master port. This covers descriptor fetches, data reads and writes, and done write-backs. Each request is held until the memory acknowledges it. Five sticky status flags feed one interrupt line through a mask. The flags are transfer complete, block complete, source word, destination word and error.

Register map (word index on `reg_addr_i`): 0 enable (bit 0), 1 next pointer, 2 live source, 3 live destination, 4 live control, 5 raw status, 6 clear (write only, reads 0), 7 mask.

Top module: `llist_dma`

## Requirements
- R1: Writing 1 to enable bit 0 (index 0) while the channel is idle starts a read at the address held in the next-pointer register (index 1) in the following cycle. Writing 0 starts nothing and produces no memory access.
- R2: A descriptor at base B is read as four words in the order B+0 (source), B+4 (destination), B+8 (next pointer), B+12 (control). Each word is copied into the matching live register, readable at indices 2, 3, 1 and 4.
- R3: Control bits [11:0] give the block length N in words. The engine performs N read/write pairs, reading at the source address and writing to the destination address, and both addresses advance by 4 after each word.
- R4: A block length of zero moves no data: the descriptor fetch is followed directly by the done write-back.
- R5: After each block, the control word with bit 31 (done) set is written to B+12. This write happens before any access to the next descriptor.
- R6: When the reloaded next pointer is non-zero, the fetch of the next descriptor starts in the cycle after the write-back is acknowledged, whatever the state of the block-complete flag.
- R7: When the reloaded next pointer is zero, finishing the block sets status bit 0 (transfer complete) and clears the enable bit, and no further access is made.
- R8: Status bits are: 0 transfer complete, 1 block complete, 2 source word read, 3 destination word written, 4 error. Writing 1 to a bit of the clear register (index 6) zeroes that status bit.
- R9: `irq_o` is high exactly when some status bit is set and its mask bit (index 7, same positions) is 1.
- R10: A memory error response sets status bit 4, clears the enable bit and stops all memory requests.
- R11: A pending memory request keeps its address, direction and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completed this cycle |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_err_i | input | 1 | Error response, valid with acknowledge |
| irq_o | output | 1 | Masked OR of status flags |

## Verification
A register write taken at an edge makes the first memory request visible after that edge. Each memory acknowledge moves the engine on at the same edge: a new request, an updated live register and the status flag all appear one cycle later. `irq_o` follows status or mask through logic alone, with no register in between. The bench drives inputs and samples outputs on the falling edge, so every value it reads has settled from the preceding rising edge. Completion is found by polling the enable bit rather than by counting cycles. The bench memory model logs every access in order, and the order and addresses of fetches, data moves and write-backs are checked against that log.

// File: rtl/llist_dma_pkg.sv
package llist_dma_pkg;
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_WB} dma_st_e;

  localparam logic [2:0] A_CHEN  = 3'd0;
  localparam logic [2:0] A_NEXT  = 3'd1;
  localparam logic [2:0] A_SRC   = 3'd2;
  localparam logic [2:0] A_DST   = 3'd3;
  localparam logic [2:0] A_CTRL  = 3'd4;
  localparam logic [2:0] A_STAT  = 3'd5;
  localparam logic [2:0] A_CLR   = 3'd6;
  localparam logic [2:0] A_MASK  = 3'd7;

  localparam int NUM_FLAGS = 5;
  localparam int F_XFER = 0;
  localparam int F_BLK  = 1;
  localparam int F_SRC  = 2;
  localparam int F_DST  = 3;
  localparam int F_ERR  = 4;
endpackage

// File: rtl/llist_dma_flags.sv
module llist_dma_flags
  import llist_dma_pkg::*;
#(
  parameter int NF = NUM_FLAGS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic          clr_we_i,
  input  logic [NF-1:0] clr_i,
  input  logic          mask_we_i,
  input  logic [NF-1:0] mask_i,
  output logic [NF-1:0] status_o,
  output logic [NF-1:0] mask_o,
  output logic          irq_o
);
  logic [NF-1:0] status_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      // a set in the same cycle wins over a clear
      status_q <= (status_q & ~(clr_we_i ? clr_i : '0)) | set_i;
      if (mask_we_i) mask_q <= mask_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);

  // R8
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((status_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/llist_dma_engine.sv
module llist_dma_engine
  import llist_dma_pkg::*;
#(
  parameter int W     = 32,
  parameter int LEN_W = 12,
  parameter int NF    = NUM_FLAGS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_we_i,
  input  logic [2:0]    sw_addr_i,
  input  logic [W-1:0]  sw_wdata_i,
  output logic          chen_o,
  output logic [W-1:0]  llp_o,
  output logic [W-1:0]  src_o,
  output logic [W-1:0]  dst_o,
  output logic [W-1:0]  ctrl_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [W-1:0]  mem_addr_o,
  output logic [W-1:0]  mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [W-1:0]  mem_rdata_i,
  input  logic          mem_err_i,
  output logic [NF-1:0] set_o
);
  localparam int          DONE_BIT = W - 1;
  localparam logic [W-1:0] DONE_M  = W'(1) << DONE_BIT;
  localparam logic [W-1:0] STEP    = W'(4);

  dma_st_e           state_q;
  logic              chen_q;
  logic [W-1:0]      llp_q, src_q, dst_q, ctrl_q, base_q, buf_q;
  logic [1:0]        idx_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              ok, bad;

  assign ok  = mem_req_o && mem_ack_i && !mem_err_i;
  assign bad = mem_req_o && mem_ack_i && mem_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      chen_q  <= 1'b0;
      llp_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      ctrl_q  <= '0;
      base_q  <= '0;
      buf_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else if (bad) begin
      chen_q  <= 1'b0;
      state_q <= S_IDLE;
    end else begin
      unique case (state_q)
        S_IDLE: if (sw_we_i) begin
          if (sw_addr_i == A_NEXT) llp_q <= sw_wdata_i;
          if (sw_addr_i == A_CHEN && sw_wdata_i[0]) begin
            chen_q  <= 1'b1;
            base_q  <= llp_q;
            idx_q   <= '0;
            state_q <= S_FETCH;
          end
        end
        S_FETCH: if (ok) begin
          unique case (idx_q)
            2'd0: src_q  <= mem_rdata_i;
            2'd1: dst_q  <= mem_rdata_i;
            2'd2: llp_q  <= mem_rdata_i;
            default: ctrl_q <= mem_rdata_i;
          endcase
          idx_q <= idx_q + 2'd1;
          if (idx_q == 2'd3) begin
            cnt_q   <= '0;
            state_q <= (mem_rdata_i[LEN_W-1:0] == '0) ? S_WB : S_RD;
          end
        end
        S_RD: if (ok) begin
          buf_q   <= mem_rdata_i;
          src_q   <= src_q + STEP;
          state_q <= S_WR;
        end
        S_WR: if (ok) begin
          dst_q   <= dst_q + STEP;
          cnt_q   <= cnt_q + 1'b1;
          state_q <= ({1'b0, cnt_q} + 1'b1 == {1'b0, ctrl_q[LEN_W-1:0]}) ? S_WB : S_RD;
        end
        S_WB: if (ok) begin
          ctrl_q <= ctrl_q | DONE_M;
          if (llp_q == '0) begin
            chen_q  <= 1'b0;
            state_q <= S_IDLE;
          end else begin
            base_q  <= llp_q;
            idx_q   <= '0;
            state_q <= S_FETCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = (state_q != S_IDLE);
    mem_we_o    = (state_q == S_WR) || (state_q == S_WB);
    mem_wdata_o = (state_q == S_WR) ? buf_q : (ctrl_q | DONE_M);
    unique case (state_q)
      S_FETCH: mem_addr_o = base_q + {{(W-4){1'b0}}, idx_q, 2'b00};
      S_RD:    mem_addr_o = src_q;
      S_WR:    mem_addr_o = dst_q;
      S_WB:    mem_addr_o = base_q + W'(12);
      default: mem_addr_o = '0;
    endcase
  end

  always_comb begin
    set_o         = '0;
    set_o[F_SRC]  = ok && state_q == S_RD;
    set_o[F_DST]  = ok && state_q == S_WR;
    set_o[F_BLK]  = ok && state_q == S_WB;
    set_o[F_XFER] = ok && state_q == S_WB && llp_q == '0;
    set_o[F_ERR]  = bad;
  end

  assign chen_o = chen_q;
  assign llp_o  = llp_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign ctrl_o = ctrl_q;

  // R11
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
  // R1
  start_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && sw_we_i && sw_addr_i == A_CHEN && sw_wdata_i[0])
      |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(llp_q)));
  // R6
  chain_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && state_q == S_WB && llp_q != '0) |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(llp_q)));
  // R7
  last_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && state_q == S_WB && llp_q == '0) |=> (!chen_q && !mem_req_o));
  // R10
  err_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> (!chen_q && !mem_req_o));
endmodule

// File: rtl/llist_dma.sv
module llist_dma
  import llist_dma_pkg::*;
#(
  parameter int W     = 32,
  parameter int LEN_W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reg_we_i,
  input  logic [2:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic         mem_req_o,
  output logic         mem_we_o,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  input  logic         mem_ack_i,
  input  logic [W-1:0] mem_rdata_i,
  input  logic         mem_err_i,
  output logic         irq_o
);
  localparam int NF = NUM_FLAGS;

  logic          chen;
  logic [W-1:0]  llp, src, dst, ctrl;
  logic [NF-1:0] set, status, mask;

  llist_dma_engine #(.W(W), .LEN_W(LEN_W), .NF(NF)) u_engine (
    .clk_i, .rst_ni,
    .sw_we_i(reg_we_i), .sw_addr_i(reg_addr_i), .sw_wdata_i(reg_wdata_i),
    .chen_o(chen), .llp_o(llp), .src_o(src), .dst_o(dst), .ctrl_o(ctrl),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ack_i, .mem_rdata_i, .mem_err_i,
    .set_o(set)
  );

  llist_dma_flags #(.NF(NF)) u_flags (
    .clk_i, .rst_ni,
    .set_i(set),
    .clr_we_i(reg_we_i && reg_addr_i == A_CLR), .clr_i(reg_wdata_i[NF-1:0]),
    .mask_we_i(reg_we_i && reg_addr_i == A_MASK), .mask_i(reg_wdata_i[NF-1:0]),
    .status_o(status), .mask_o(mask), .irq_o
  );

  always_comb begin
    unique case (reg_addr_i)
      A_CHEN:  reg_rdata_o = {{(W-1){1'b0}}, chen};
      A_NEXT:  reg_rdata_o = llp;
      A_SRC:   reg_rdata_o = src;
      A_DST:   reg_rdata_o = dst;
      A_CTRL:  reg_rdata_o = ctrl;
      A_STAT:  reg_rdata_o = {{(W-NF){1'b0}}, status};
      A_MASK:  reg_rdata_o = {{(W-NF){1'b0}}, mask};
      default: reg_rdata_o = '0;
    endcase
  end

  // R9
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_MASK && reg_wdata_i[NF-1:0] == '0 && set == '0) |=> !irq_o);
endmodule

// File: tb/llist_dma_tb.sv
module llist_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] mem [0:1023];
  logic [31:0] log_a [0:255];
  logic        log_w [0:255];
  int          log_n = 0;

  always #4 clk = ~clk;

  llist_dma u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
    .irq_o(irq)
  );

  // memory model: one-cycle response, addresses with bit 15 set answer with error
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_err <= mem_addr[15];
      mem_rdata <= mem_addr[15] ? 32'h0 : mem[mem_addr[11:2]];
      if (mem_we && !mem_addr[15]) mem[mem_addr[11:2]] <= mem_wdata;
      if (log_n < 256) begin
        log_a[log_n] <= mem_addr;
        log_w[log_n] <= mem_we;
      end
      log_n <= log_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      rd(3'd0, v);
      if (v == 32'd0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic put_desc(input int base, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] n, input logic [31:0] c);
    mem[base/4] = s; mem[base/4+1] = d; mem[base/4+2] = n; mem[base/4+3] = c;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R8 reset register", v, 32'h0);
    end
    check("R9 reset irq", {31'b0, irq}, 32'h0);
    check("R11 reset req", {31'b0, mem_req}, 32'h0);
  endtask

  task automatic t_enable_zero();
    int l0;
    logic [31:0] v;
    wr(3'd1, 32'h100);
    l0 = log_n;
    wr(3'd0, 32'h0);
    repeat (10) @(negedge clk);
    check("R1 no access on enable=0", 32'(log_n - l0), 32'h0);
    rd(3'd0, v);
    check("R1 enable stays 0", v, 32'h0);
  endtask

  task automatic t_chain();
    int l0;
    logic [31:0] v;
    put_desc(32'h100, 32'h200, 32'h300, 32'h140, 32'h3);
    put_desc(32'h140, 32'h240, 32'h340, 32'h0, 32'h2);
    for (int i = 0; i < 3; i++) mem[32'h200/4 + i] = 32'hA0 + i;
    for (int i = 0; i < 2; i++) mem[32'h240/4 + i] = 32'hB0 + i;
    wr(3'd1, 32'h100);
    l0 = log_n;
    wr(3'd0, 32'h1);
    wait_idle();
    check("R7 access count", 32'(log_n - l0), 32'd20);
    for (int i = 0; i < 4; i++) begin
      check("R2 fetch order", log_a[l0+i], 32'h100 + 32'(4*i));
      check("R2 fetch is read", {31'b0, log_w[l0+i]}, 32'h0);
    end
    check("R3 first data read", log_a[l0+4], 32'h200);
    check("R3 first data write", log_a[l0+5], 32'h300);
    check("R3 third data read", log_a[l0+8], 32'h208);
    check("R5 writeback addr", log_a[l0+10], 32'h10C);
    check("R5 writeback is write", {31'b0, log_w[l0+10]}, 32'h1);
    check("R6 next fetch addr", log_a[l0+11], 32'h140);
    for (int i = 0; i < 3; i++) check("R3 block A data", mem[32'h300/4 + i], 32'hA0 + 32'(i));
    for (int i = 0; i < 2; i++) check("R3 block B data", mem[32'h340/4 + i], 32'hB0 + 32'(i));
    check("R5 done A", mem[32'h10C/4], 32'h8000_0003);
    check("R5 done B", mem[32'h14C/4], 32'h8000_0002);
    rd(3'd2, v); check("R2 live source", v, 32'h248);
    rd(3'd3, v); check("R2 live dest", v, 32'h348);
    rd(3'd1, v); check("R2 live next", v, 32'h0);
    rd(3'd4, v); check("R2 live ctrl", v, 32'h8000_0002);
    rd(3'd0, v); check("R7 enable cleared", v, 32'h0);
    rd(3'd5, v); check("R7 status after chain", v, 32'h0F);
    check("R9 masked irq low", {31'b0, irq}, 32'h0);
    wr(3'd7, 32'h2);
    check("R9 irq on block flag", {31'b0, irq}, 32'h1);
    wr(3'd6, 32'h3);
    rd(3'd5, v); check("R8 partial clear", v, 32'h0C);
    check("R9 irq after clear", {31'b0, irq}, 32'h0);
    wr(3'd6, 32'h1F);
    rd(3'd5, v); check("R8 full clear", v, 32'h0);
    wr(3'd7, 32'h0);
  endtask

  task automatic t_zero_len();
    int l0;
    logic [31:0] v;
    mem[32'h3C0/4] = 32'h5555;
    put_desc(32'h180, 32'h200, 32'h3C0, 32'h0, 32'h0);
    wr(3'd1, 32'h180);
    l0 = log_n;
    wr(3'd0, 32'h1);
    wait_idle();
    check("R4 access count", 32'(log_n - l0), 32'd5);
    check("R4 writeback follows fetch", log_a[l0+4], 32'h18C);
    check("R4 done set", mem[32'h18C/4], 32'h8000_0000);
    check("R4 dest untouched", mem[32'h3C0/4], 32'h5555);
    rd(3'd5, v); check("R4 status", v, 32'h03);
    wr(3'd6, 32'h1F);
  endtask

  task automatic t_error();
    int l0;
    logic [31:0] v;
    put_desc(32'h1C0, 32'h8000, 32'h380, 32'h0, 32'h2);
    wr(3'd1, 32'h1C0);
    l0 = log_n;
    wr(3'd0, 32'h1);
    wait_idle();
    repeat (10) @(negedge clk);
    check("R10 stops after error", 32'(log_n - l0), 32'd5);
    check("R10 failing address", log_a[l0+4], 32'h8000);
    check("R10 no done writeback", mem[32'h1CC/4], 32'h2);
    rd(3'd5, v); check("R10 error flag", v, 32'h10);
    rd(3'd0, v); check("R10 enable cleared", v, 32'h0);
    wr(3'd7, 32'h10);
    check("R9 irq on error", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_zero();
    t_chain();
    t_zero_len();
    t_error();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule